// File: doc/BRIEF.md
# Strobe-Reloaded Watchdog Timer

This block is a down-counting watchdog for a host that must prove it is alive. A slow enable tick, nominally 32 Hz and derived from the crystal oscillator, steps the counter down once per 31.25 ms. The counter only moves while the oscillator-running input is high. Software sets the timeout through an 8-bit control byte. The byte carries three fields: a reload strobe, an active-low write-enable (lock) bit, and a 6-bit load value.

The load value is protected. A control write changes it only when that same write carries a 0 in the lock bit. A later write with the lock bit at 1 seals the value. Writing the strobe bit copies the load value into the counter. When the counter steps from one to zero, a sticky watchdog flag is set. An interrupt request follows the flag while the interrupt enable is high. A flags-read strobe clears the flag.

A load value of zero turns the watchdog off. The load register resets to zero, so software must program it after power-up. All pins are plain control and status signals. Data moves only through single-cycle register writes, so the block has no back-pressure.

Top module: `wdog_strobe_top`

## Requirements
- R1: After reset the counter is 0, the flag and the interrupt request are low, and the readback byte is 0x40: lock bit 1, load value 0.
- R2: A control write with bit 6 equal to 0 stores bits 5:0 as the load value. The readback byte is {0, lock bit, load value}, with the lock bit in bit 6 and the load value in bits 5:0.
- R3: A control write with bit 6 equal to 1 sets the lock bit and leaves the load value unchanged, whatever bits 5:0 hold.
- R4: A control write with bit 7 equal to 1 loads the counter with the load value in effect after that write, in the same cycle. Bit 7 always reads back as 0.
- R5: With no write pending, the counter decrements by one on each cycle where tick and osc_run are both high and the counter is nonzero. It holds when either input is low.
- R6: The step from 1 to 0 sets the flag on that same clock edge. The counter then stays at 0 and raises no further flag until a strobe reloads it.
- R7: flag_rd clears the flag on the next edge. If a timeout happens in the same cycle, the flag stays set.
- R8: irq_req is high exactly when the flag is high and irq_en is high.
- R9: While the load value is 0 the counter is held at 0 and never sets the flag. A write that makes the load value 0 clears a running count without setting the flag.
- R10: When a strobe and a tick arrive in the same cycle, the reload wins. The counter takes the load value, not the load value minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte: [7] reload strobe, [6] lock (active-low write-enable), [5:0] load value |
| ctl_rdata | output | 8 | Readback: {0, lock, load value} |
| tick | input | 1 | 32 Hz step enable, one cycle wide |
| osc_run | input | 1 | Oscillator running; counting is frozen while low |
| flag_rd | input | 1 | Flags-register read strobe; clears the flag |
| irq_en | input | 1 | Watchdog interrupt enable |
| wd_count | output | 6 | Current counter value |
| wd_flag | output | 1 | Sticky timeout flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- a strobe with the lock set loads the value that was read back just before it;
- counting steps by exactly one only on a qualified tick and holds otherwise;
- the flag rises only with the counter at zero;
- a flags read clears the flag unless a timeout coincides;
- a zero load value pins the counter to zero;
- the interrupt request never appears without the flag.

Only the bench's scenarios can show the rest:
- which writes change the protected load field and which are refused;
- that the counter stays parked at zero after a timeout;
- the strobe-versus-tick priority;
- the exact cycle in which the flag and interrupt appear for a given load value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned LOAD_W   = 6;
  localparam int unsigned CTL_W    = LOAD_W + 2;
  localparam int unsigned STB_BIT  = LOAD_W + 1;
  localparam int unsigned LOCK_BIT = LOAD_W;
endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg #(
  parameter int unsigned LW = wdog_pkg::LOAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [LW+1:0] wdata,
  output logic [LW-1:0] load_q,
  output logic [LW-1:0] load_nx,
  output logic          lock_q,
  output logic          strobe
);
  localparam int unsigned STB  = LW + 1;
  localparam int unsigned LOCK = LW;

  // load field is writable only by a byte that clears the lock bit
  always_comb begin
    load_nx = load_q;
    if (wr && !wdata[LOCK]) load_nx = wdata[LW-1:0];
  end

  assign strobe = wr && wdata[STB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      lock_q <= 1'b1;
    end else begin
      load_q <= load_nx;
      if (wr) lock_q <= wdata[LOCK];
    end
  end
endmodule

// File: rtl/wdog_down_cnt.sv
module wdog_down_cnt #(
  parameter int unsigned LW = wdog_pkg::LOAD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [LW-1:0] load_nx,
  input  logic          step,
  output logic [LW-1:0] count,
  output logic          expire
);
  localparam logic [LW-1:0] ONE = LW'(1);

  logic enabled;
  assign enabled = (load_nx != '0);
  assign expire  = !strobe && enabled && step && (count == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (strobe) begin
      count <= load_nx;            // reload beats a coincident tick
    end else if (!enabled) begin
      count <= '0;                 // zero load value disables
    end else if (step && count != '0) begin
      count <= count - ONE;
    end
  end
endmodule

// File: rtl/wdog_flag_unit.sv
module wdog_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic flag_rd,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (expire)  flag <= 1'b1;  // a new timeout outranks the read clear
    else if (flag_rd) flag <= 1'b0;
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/wdog_strobe_top.sv
module wdog_strobe_top #(
  parameter int unsigned LOAD_W = wdog_pkg::LOAD_W,
  localparam int unsigned CW    = LOAD_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CW-1:0]     ctl_wdata,
  output logic [CW-1:0]     ctl_rdata,
  input  logic              tick,
  input  logic              osc_run,
  input  logic              flag_rd,
  input  logic              irq_en,
  output logic [LOAD_W-1:0] wd_count,
  output logic              wd_flag,
  output logic              irq_req
);
  logic [LOAD_W-1:0] load_q, load_nx;
  logic              lock_q, strobe, expire;

  wdog_ctl_reg #(.LW(LOAD_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .load_q(load_q), .load_nx(load_nx), .lock_q(lock_q), .strobe(strobe)
  );

  wdog_down_cnt #(.LW(LOAD_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .load_nx(load_nx),
    .step(tick && osc_run), .count(wd_count), .expire(expire)
  );

  wdog_flag_unit u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .flag_rd(flag_rd),
    .irq_en(irq_en), .flag(wd_flag), .irq(irq_req)
  );

  assign ctl_rdata = {1'b0, lock_q, load_q};
endmodule

// File: rtl/wdog_strobe_chk.sv
module wdog_strobe_chk #(
  parameter int unsigned LW = wdog_pkg::LOAD_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ctl_wr,
  input logic [LW+1:0] ctl_wdata,
  input logic [LW+1:0] ctl_rdata,
  input logic          tick,
  input logic          osc_run,
  input logic          flag_rd,
  input logic [LW-1:0] wd_count,
  input logic          wd_flag,
  input logic          irq_req
);
  localparam logic [LW-1:0] ONE = LW'(1);

  // R4 / R10: locked strobe loads the value read back before it
  a_r4_strobe_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[LW+1] && ctl_wdata[LW] |=> wd_count == $past(ctl_rdata[LW-1:0]));

  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && tick && osc_run && wd_count != '0 && ctl_rdata[LW-1:0] != '0
      |=> wd_count == $past(wd_count) - ONE);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && !(tick && osc_run) && ctl_rdata[LW-1:0] != '0 |=> $stable(wd_count));

  a_r6_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_flag) |-> wd_count == '0);

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flag_rd && !(tick && osc_run && wd_count == ONE) |=> !wd_flag);

  a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wd_flag);

  a_r9_zero_parks: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr && ctl_rdata[LW-1:0] == '0 |=> wd_count == '0);
endmodule

bind wdog_strobe_top wdog_strobe_chk #(.LW(LOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .ctl_rdata(ctl_rdata), .tick(tick), .osc_run(osc_run), .flag_rd(flag_rd),
  .wd_count(wd_count), .wd_flag(wd_flag), .irq_req(irq_req)
);

// File: tb/test_wdog_strobe_top.sv
module test_wdog_strobe_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic       tick = 1'b0, osc_run = 1'b0, flag_rd = 1'b0, irq_en = 1'b0;
  logic [5:0] wd_count;
  logic       wd_flag, irq_req;
  int         n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  wdog_strobe_top i_wdog_strobe_top (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tick(tick), .osc_run(osc_run), .flag_rd(flag_rd),
    .irq_en(irq_en), .wd_count(wd_count), .wd_flag(wd_flag), .irq_req(irq_req)
  );

  // {wr, wdata, tick, osc, frd, ien, exp_cnt, exp_flag, exp_irq, exp_rdata, req}
  localparam int NV = 16;
  localparam logic [32:0] VEC [NV] = '{
    {1'b1,8'h05,4'b0000, 6'd0,1'b0,1'b0,8'h05, 4'd2},  // R2 load 5
    {1'b1,8'h40,4'b0000, 6'd0,1'b0,1'b0,8'h45, 4'd3},  // R3 lock
    {1'b1,8'hC0,4'b0000, 6'd5,1'b0,1'b0,8'h45, 4'd4},  // R4 strobe
    {1'b0,8'h00,4'b1100, 6'd4,1'b0,1'b0,8'h45, 4'd5},  // R5 step
    {1'b0,8'h00,4'b1000, 6'd4,1'b0,1'b0,8'h45, 4'd5},  // R5 osc stopped
    {1'b0,8'h00,4'b1100, 6'd3,1'b0,1'b0,8'h45, 4'd5},
    {1'b0,8'h00,4'b1100, 6'd2,1'b0,1'b0,8'h45, 4'd5},
    {1'b0,8'h00,4'b1100, 6'd1,1'b0,1'b0,8'h45, 4'd5},
    {1'b0,8'h00,4'b1101, 6'd0,1'b1,1'b1,8'h45, 4'd6},  // R6 timeout, R8 irq
    {1'b0,8'h00,4'b1100, 6'd0,1'b1,1'b0,8'h45, 4'd8},  // R8 irq masked
    {1'b0,8'h00,4'b0010, 6'd0,1'b0,1'b0,8'h45, 4'd7},  // R7 read clears
    {1'b0,8'h00,4'b1100, 6'd0,1'b0,1'b0,8'h45, 4'd6},  // R6 parked
    {1'b1,8'hC0,4'b1100, 6'd5,1'b0,1'b0,8'h45, 4'd10}, // R10 reload wins
    {1'b1,8'h00,4'b0000, 6'd0,1'b0,1'b0,8'h00, 4'd9},  // R9 zero clears
    {1'b1,8'hC0,4'b1100, 6'd0,1'b0,1'b0,8'h40, 4'd9},  // R9 strobe of zero
    {1'b0,8'h00,4'b1100, 6'd0,1'b0,1'b0,8'h40, 4'd9}   // R9 stays off
  };

  task automatic drive(input logic w, input logic [7:0] d, input logic [3:0] ctl);
    @(negedge clk);
    ctl_wr = w; ctl_wdata = d;
    {tick, osc_run, flag_rd, irq_en} = ctl;
    @(posedge clk);
    #2;
  endtask

  task automatic check(input int req, input logic [5:0] ec, input logic ef,
                       input logic ei, input logic [7:0] er);
    n_run++;
    if (wd_count !== ec || wd_flag !== ef || irq_req !== ei || ctl_rdata !== er) begin
      n_fail++;
      $display("FAIL R%0d: cnt=%0d flag=%b irq=%b rd=%h expected cnt=%0d flag=%b irq=%b rd=%h",
               req, wd_count, wd_flag, irq_req, ctl_rdata, ec, ef, ei, er);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(1, 6'd0, 1'b0, 1'b0, 8'h40);  // R1 reset state
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][32], VEC[i][31:24], VEC[i][23:20]);
      check(int'(VEC[i][3:0]), VEC[i][19:14], VEC[i][13], VEC[i][12], VEC[i][11:4]);
    end

    // R1: reset mid-run restores the defaults
    drive(1'b1, 8'h03, 4'b0000);
    @(negedge clk) rst_n = 1'b0;
    #2;
    check(1, 6'd0, 1'b0, 1'b0, 8'h40);
    @(negedge clk) rst_n = 1'b1;

    drive(1'b1, 8'h02, 4'b0000); check(2, 6'd0, 1'b0, 1'b0, 8'h02);
    drive(1'b1, 8'h7F, 4'b0000); check(3, 6'd0, 1'b0, 1'b0, 8'h42);  // R3 refused
    drive(1'b1, 8'hC2, 4'b0000); check(4, 6'd2, 1'b0, 1'b0, 8'h42);
    drive(1'b0, 8'h00, 4'b1100); check(5, 6'd1, 1'b0, 1'b0, 8'h42);
    drive(1'b0, 8'h00, 4'b1110); check(7, 6'd0, 1'b1, 1'b0, 8'h42);  // R7 set wins
    drive(1'b0, 8'h00, 4'b0001); check(8, 6'd0, 1'b1, 1'b1, 8'h42);
    drive(1'b0, 8'h00, 4'b0011); check(7, 6'd0, 1'b0, 1'b0, 8'h42);

    drive(1'b0, 8'h00, 4'b0000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule